// File: doc/BRIEF.md
# Serial Bus Word Encoder with Fail-Safe Timer

This block is the transmit half of a terminal on a MIL-STD-1553 style serial bus. From a 12 MHz clock it makes a free-running 1 MHz encode strobe. When the active-low enable is held, it sends Manchester II words on a single serial line. Each word lasts 20 bit times:

- a 3-bit-time sync, which is a command/status sync or a data sync;
- the 16 data bits, most significant first;
- an odd parity bit.

A SEND window output marks the 16 data bit times.

Software writes each word into a holding register. The block copies that register into a shift register when the SEND window opens. So the next word can be written while the current word is still being sent. Words follow one another with no gap for as long as enable stays low. The block also times each continuous transmission. If a message runs longer than 768 µs, a fail-safe stops the line and latches a flag. The flag is cleared by a clear pulse, which the receive side gives when it sees a valid command for this terminal. Master reset also clears it.

Top module: `bus_word_encoder`

## Requirements
- R1: `strobe_o` is a free-running encode strobe with a period of 12 clocks: 6 clocks high, then 6 clocks low. Reset leaves it high at phase zero.
- R2: A word starts only at a falling edge of `strobe_o` that sees `enc_en_n` low. While `enc_en_n` stays high, `line_o` stays low and `tx_inh_o` stays high. Each line bit window begins 6 clocks after a strobe fall, which is on a strobe rise.
- R3: A word is 20 bit windows of 12 clocks each: windows 0-2 hold the sync, windows 3-18 hold data bits 15 down to 0, and window 19 holds the parity bit. Parity makes the count of ones over the 16 data bits and the parity bit odd. A 1 is sent high for 6 clocks and then low for 6 clocks; a 0 is sent low then high. While nothing is sent, `line_o` is 0 and `tx_inh_o` is 1.
- R4: `cmd_sync_i` is sampled at the first strobe rise of each word. A 1 gives a command/status sync, which is high for 18 clocks and then low for 18 clocks. A 0 gives a data sync, which is the inverse.
- R5: `send_o` rises on the same clock as the fourth strobe fall of a word and stays high for 192 clocks. It is high only while the line is driven. Seen in line half-bit units (0-39), it covers halves 5 through 36.
- R6: A write pulse on `wr_i` stores `data_i` in a holding register. The holding register is copied into the shift register on the clock where `send_o` rises. A write made after that point does not change the word being sent; it is used for the next word.
- R7: `enc_en_n` is sampled at the strobe rise of parity window 19's predecessor edge (the rise that follows the fall of `send_o`). If it is low there, the next word starts on the very next strobe fall, with no gap on the line. If it is high, the message ends once the parity bit has been sent.
- R8: A transmission that has been active for 9216 clocks in a row (768 µs) is cut off at once. `fs_o` is then set, `line_o` goes low and `tx_inh_o` goes high. A message that starts from idle therefore drives the line for exactly 9210 clocks.
- R9: While `fs_o` is set, no word starts, even with `enc_en_n` low. A one-clock pulse on `fs_clr_i` clears `fs_o`, and a new message may then start.
- R10: An active-low `rst_n` acts asynchronously and overrides every other input. It stops any word, clears `fs_o`, drives `line_o` low, drives `tx_inh_o` high and drives `send_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| enc_en_n | input | 1 | Encoder enable, active low |
| cmd_sync_i | input | 1 | Sync type: 1 gives command/status, 0 gives data |
| wr_i | input | 1 | Write strobe for the holding register |
| data_i | input | DATA_W | Word to transmit |
| fs_clr_i | input | 1 | Fail-safe clear pulse |
| strobe_o | output | 1 | 1 MHz encode strobe |
| send_o | output | 1 | Data shifting window |
| line_o | output | 1 | Manchester serial output |
| tx_inh_o | output | 1 | High when the line driver must be off |
| fs_o | output | 1 | Fail-safe time-out flag |

## Verification
The bound checker watches the SEND window on every cycle. It checks that the window rises together with a strobe fall, lasts 192 clocks and never appears while the line is off. It also checks that the fail-safe flag holds until it is cleared and that the line stays off while the flag is set. The bench scenarios are what show the bit-exact line waveform for each sync type and parity case. They also show the holding-register timing, gap-free word chaining, the 9210-clock cut-off length, the restart after a clear, and the reset override.

// File: rtl/bus_word_encoder.sv
`timescale 1ns/1ps
module bus_word_encoder #(
  parameter int CLK_PER_HALF = 6,
  parameter int DATA_W       = 16,
  parameter int FAILSAFE_US  = 768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_en_n,
  input  logic              cmd_sync_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              fs_clr_i,
  output logic              strobe_o,
  output logic              send_o,
  output logic              line_o,
  output logic              tx_inh_o,
  output logic              fs_o
);
  localparam int STROBE_PER = 2 * CLK_PER_HALF;
  localparam int PH_W       = $clog2(STROBE_PER);
  localparam int WORD_SLOTS = DATA_W + 4;
  localparam int SLOT_W     = $clog2(WORD_SLOTS);
  localparam int FS_CLKS    = FAILSAFE_US * STROBE_PER;
  localparam int FS_W       = $clog2(FS_CLKS + 1);

  localparam logic [SLOT_W-1:0] S_SYNC_MID  = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] S_SYNC_END  = SLOT_W'(2);
  localparam logic [SLOT_W-1:0] S_DATA0     = SLOT_W'(3);
  localparam logic [SLOT_W-1:0] S_DATA_LAST = SLOT_W'(DATA_W + 2);
  localparam logic [SLOT_W-1:0] S_PAR       = SLOT_W'(DATA_W + 3);

  logic [PH_W-1:0]   ph;
  logic [SLOT_W-1:0] slot, lidx;
  logic [FS_W-1:0]   fcnt;
  logic [DATA_W-1:0] hold, sh;
  logic busy, cont, lon, sync_cmd, par, fs, v;

  wire rise_ev = (ph == PH_W'(STROBE_PER - 1));
  wire fall_ev = (ph == PH_W'(CLK_PER_HALF - 1));
  wire second  = (ph >= PH_W'(CLK_PER_HALF));
  wire trip    = busy && (fcnt == FS_W'(FS_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ph <= '0;
    else if (rise_ev) ph <= '0;
    else              ph <= ph + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0;
      slot <= '0;
    end else if (trip) begin
      busy <= 1'b0;
      slot <= '0;
    end else if (fall_ev) begin
      if (busy) begin
        if (slot == S_PAR) begin
          busy <= cont;
          slot <= '0;
        end else begin
          slot <= slot + 1'b1;
        end
      end else if (!enc_en_n && !fs) begin
        busy <= 1'b1;
        slot <= '0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cont     <= 1'b0;
      sync_cmd <= 1'b0;
    end else if (rise_ev && busy) begin
      if (slot == S_PAR) cont     <= !enc_en_n;
      if (slot == '0)    sync_cmd <= cmd_sync_i;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lon  <= 1'b0;
      lidx <= '0;
    end else if (trip) begin
      lon  <= 1'b0;
    end else if (rise_ev) begin
      lon  <= busy;
      lidx <= slot;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    hold <= '0;
    else if (wr_i) hold <= data_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh  <= '0;
      par <= 1'b0;
    end else if (fall_ev && busy && slot == S_SYNC_END) begin
      sh  <= hold;
      par <= ~^hold;
    end else if (rise_ev && lon && lidx >= S_DATA0 && lidx < S_DATA_LAST) begin
      sh  <= {sh[DATA_W-2:0], 1'b0};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     fcnt <= '0;
    else if (!busy) fcnt <= '0;
    else            fcnt <= fcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        fs <= 1'b0;
    else if (trip)     fs <= 1'b1;
    else if (fs_clr_i) fs <= 1'b0;

  always_comb begin
    if (lidx == '0)              v = sync_cmd;
    else if (lidx == S_SYNC_MID) v = sync_cmd ^ second;
    else if (lidx == S_SYNC_END) v = !sync_cmd;
    else if (lidx == S_PAR)      v = par ^ second;
    else                         v = sh[DATA_W-1] ^ second;
  end

  assign strobe_o = (ph < PH_W'(CLK_PER_HALF));
  assign send_o   = busy && (slot >= S_DATA0) && (slot <= S_DATA_LAST);
  assign line_o   = lon & v;
  assign tx_inh_o = !lon;
  assign fs_o     = fs;
endmodule

// File: rtl/bus_word_encoder_chk.sv
`timescale 1ns/1ps
module bus_word_encoder_chk #(
  parameter int SEND_CLKS = 192
) (
  input logic clk,
  input logic rst_n,
  input logic strobe_o,
  input logic send_o,
  input logic tx_inh_o,
  input logic fs_o,
  input logic fs_clr_i
);
  localparam int CW = $clog2(SEND_CLKS + 2);
  logic [CW-1:0] scnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      scnt <= '0;
    else if (send_o) scnt <= scnt + 1'b1;
    else             scnt <= '0;

  assert_send_on_strobe_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(send_o) |-> $fell(strobe_o));

  assert_send_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(send_o) && !fs_o) |-> (scnt == CW'(SEND_CLKS)));

  assert_send_while_driving_R5: assert property (@(posedge clk) disable iff (!rst_n)
    send_o |-> !tx_inh_o);

  assert_fs_line_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fs_o |-> tx_inh_o);

  assert_fs_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_o && !fs_clr_i) |=> fs_o);
endmodule

bind bus_word_encoder bus_word_encoder_chk #(.SEND_CLKS(DATA_W * 2 * CLK_PER_HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe_o(strobe_o), .send_o(send_o),
  .tx_inh_o(tx_inh_o), .fs_o(fs_o), .fs_clr_i(fs_clr_i)
);

// File: tb/bus_word_encoder_tb.sv
`timescale 1ns/1ps
module bus_word_encoder_tb_top;
  localparam int CLK_PERIOD = 84;
  localparam logic [16:0] VEC [0:5] = '{17'h1_0000, 17'h0_FFFF, 17'h1_A5C3,
                                         17'h0_8001, 17'h1_7FFF, 17'h0_0001};

  logic clk = 1'b0;
  logic rst_n, enc_en_n, cmd_sync_i, wr_i, fs_clr_i;
  logic [15:0] data_i;
  logic strobe_o, send_o, line_o, tx_inh_o, fs_o;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_word_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .enc_en_n(enc_en_n), .cmd_sync_i(cmd_sync_i),
    .wr_i(wr_i), .data_i(data_i), .fs_clr_i(fs_clr_i), .strobe_o(strobe_o),
    .send_o(send_o), .line_o(line_o), .tx_inh_o(tx_inh_o), .fs_o(fs_o)
  );

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic logic exp_half(input logic [15:0] d, input logic cmd, input int h);
    int b;
    logic bitv;
    logic [15:0] t;
    b = h / 2;
    if (b < 3) return cmd ? (h < 3) : (h >= 3);
    if (b == 19) bitv = ~^d;
    else begin
      t = d >> (18 - b);
      bitv = t[0];
    end
    return (h % 2 == 1) ? ~bitv : bitv;
  endfunction

  task automatic wait_start(input string r);
    logic ps;
    bit seen;
    ps = strobe_o;
    seen = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (!tx_inh_o) begin
        seen = 1;
        break;
      end
      ps = strobe_o;
    end
    chk(r, int'(seen), 1);
    chk("R2 window opens on strobe rise", int'({ps, strobe_o}), 1);
  endtask

  task automatic check_word(input logic [15:0] d, input logic cmd, input bit do_wr,
                            input logic [15:0] wd, input logic wcmd);
    for (int h = 0; h < 40; h++) begin
      repeat (2) @(negedge clk);
      if (h < 6) chk("R4 sync half", int'(line_o), int'(exp_half(d, cmd, h)));
      else       chk("R3 line half", int'(line_o), int'(exp_half(d, cmd, h)));
      chk("R5 send window", int'(send_o), int'(h >= 5 && h <= 36));
      if (do_wr && h == 6) begin
        data_i = wd;
        wr_i = 1'b1;
        cmd_sync_i = wcmd;
        @(negedge clk);
        wr_i = 1'b0;
        repeat (3) @(negedge clk);
      end else begin
        repeat (4) @(negedge clk);
      end
    end
  endtask

  task automatic load(input logic [15:0] d);
    data_i = d;
    wr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cnt;
    rst_n = 1'b0; enc_en_n = 1'b1; cmd_sync_i = 1'b0; wr_i = 1'b0;
    fs_clr_i = 1'b0; data_i = '0;
    repeat (5) @(negedge clk);
    chk("R10 reset inh", int'(tx_inh_o), 1);
    chk("R10 reset line", int'(line_o), 0);
    chk("R10 reset send", int'(send_o), 0);
    chk("R10 reset fs", int'(fs_o), 0);
    chk("R1 reset strobe high", int'(strobe_o), 1);
    rst_n = 1'b1;

    // R1 strobe shape
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!strobe_o) break;
    end
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (strobe_o) break;
    end
    cnt = 0;
    for (int k = 0; k < 40; k++) begin
      if (!strobe_o) break;
      cnt++;
      @(negedge clk);
    end
    chk("R1 strobe high clocks", cnt, 6);
    cnt = 0;
    for (int k = 0; k < 40; k++) begin
      if (strobe_o) break;
      cnt++;
      @(negedge clk);
    end
    chk("R1 strobe low clocks", cnt, 6);

    // R2 idle with enable high
    cnt = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (!tx_inh_o || line_o) cnt++;
    end
    chk("R2 idle no drive", cnt, 0);

    // vector table: single-word messages
    for (int i = 0; i < 6; i++) begin
      load(VEC[i][15:0]);
      cmd_sync_i = VEC[i][16];
      enc_en_n = 1'b0;
      wait_start("R2 start");
      enc_en_n = 1'b1;
      check_word(VEC[i][15:0], VEC[i][16], 1'b0, '0, 1'b0);
      chk("R7 single word ends", int'(tx_inh_o), 1);
      cnt = 0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (!tx_inh_o) cnt++;
      end
      chk("R7 no second word", cnt, 0);
    end

    // R6/R7 back-to-back, next word written after send rises
    load(16'h3C96);
    cmd_sync_i = 1'b1;
    enc_en_n = 1'b0;
    wait_start("R7 start");
    check_word(16'h3C96, 1'b1, 1'b1, 16'hE001, 1'b0);
    enc_en_n = 1'b1;
    chk("R7 no gap", int'(tx_inh_o), 0);
    check_word(16'hE001, 1'b0, 1'b0, '0, 1'b0);
    chk("R6 chained word done", int'(tx_inh_o), 1);

    // R8 fail-safe trip
    load(16'h1234);
    enc_en_n = 1'b0;
    wait_start("R8 start");
    cnt = 1;
    for (int k = 0; k < 12000; k++) begin
      @(negedge clk);
      if (tx_inh_o) break;
      cnt++;
    end
    chk("R8 drive length", cnt, 9210);
    chk("R8 fs set", int'(fs_o), 1);
    chk("R8 line low", int'(line_o), 0);

    // R9 blocked while flagged
    cnt = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (!tx_inh_o) cnt++;
    end
    chk("R9 blocked", cnt, 0);
    chk("R9 fs held", int'(fs_o), 1);
    fs_clr_i = 1'b1;
    @(negedge clk);
    fs_clr_i = 1'b0;
    chk("R9 fs cleared", int'(fs_o), 0);
    wait_start("R9 restart");

    // let it trip again, then R10 reset clears it
    for (int k = 0; k < 12000; k++) begin
      @(negedge clk);
      if (tx_inh_o) break;
    end
    chk("R8 second trip", int'(fs_o), 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 fs cleared by reset", int'(fs_o), 0);
    cnt = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (!tx_inh_o || send_o) cnt++;
    end
    chk("R10 reset overrides enable", cnt, 0);
    rst_n = 1'b1;
    wait_start("R10 start after reset");
    repeat (50) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 mid-word inh", int'(tx_inh_o), 1);
    chk("R10 mid-word line", int'(line_o), 0);
    chk("R10 mid-word send", int'(send_o), 0);
    enc_en_n = 1'b1;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule